// File: doc/BRIEF.md
# Two-Port Burst-of-Two Static Memory

This block models a static memory with one port that only reads and one that only writes. Every access moves two 18-bit words. The block runs on one clock at twice the command rate. The output `cmd_beat` is high during the beat that leads up to a command edge; the next edge is the other beat, which carries the second half of a write. A read and a write may both start at the same command edge, and neither port waits on the other.

A write takes its first data word and that word's lane enables on the command edge. It takes its address, second word and second lane enables on the following beat. The finished write sits one command cycle in a write buffer and then goes into two banks, one bank for each word of the burst. A read that starts while a matching write is still in the buffer takes its data from the buffer, merged lane by lane. A read sees every write whose command edge is at least one command cycle earlier.

Read data leaves through a short pipeline. Its length is set by a latency strap that the block latches only while reset is held. The output is 1.5 command cycles after the read edge when the strap is high and 1 command cycle when it is low.

Top module: `dual_port_burst_sram`

## Requirements
- R1: A read and a write may start on the same command edge, at different addresses, and each completes exactly as it would alone.
- R2: After reset is released, `cmd_beat` is 1 until the first clock edge and then toggles on every edge. A command edge is an edge taken while `cmd_beat` is 1.
- R3: `rd_sel_n` low at a command edge starts a read and captures `rd_addr` on that edge. On any other edge `rd_sel_n` and `rd_addr` are ignored.
- R4: `wr_sel_n` low at a command edge captures `wr_data` as word 0 and `wr_lane_n` as its lane enables. The next edge captures `wr_addr`, word 1 and word 1's lane enables.
- R5: Each lane enable is active low. Bit 0 guards data bits 8:0 and bit 1 guards bits 17:9. Where an enable is high, the stored bits stay unchanged.
- R6: With the strap latched low, a read whose command edge is t shows word 0 on `rd_data` after edge t+2 and word 1 after edge t+3.
- R7: With the strap latched high, the same read shows word 0 after edge t+3 and word 1 after edge t+4.
- R8: `rd_valid` is 1 exactly while a read word is on `rd_data`. At all other times `rd_valid` is 0 and `rd_data` is 0, so a read drives the output for exactly two beats.
- R9: A read returns the merged data of every write whose command edge came at least two edges before the read's command edge, including one still in the buffer. It does not return the data of a write that starts on the same edge.
- R10: Once a write has started, it completes whatever `wr_sel_n` does on the next beat. `wr_sel_n` high at a command edge leaves the memory untouched, whatever `wr_addr`, `wr_data` and `wr_lane_n` carry.
- R11: `lat_strap` is sampled only while `rst_n` is low. Changing it during operation does not change the read latency.
- R12: While reset is held and on the first cycle after it, `rd_valid` is 0 and `rd_data` is 0. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, two beats per command cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_strap | input | 1 | Latency strap: 1 gives 1.5 cycles, 0 gives 1 cycle; latched during reset |
| rd_sel_n | input | 1 | Active-low read start, sampled at command edges |
| rd_addr | input | AW | Read address |
| wr_sel_n | input | 1 | Active-low write start, sampled at command edges |
| wr_addr | input | AW | Write address, sampled on the beat after the command edge |
| wr_data | input | 18 | Write data: word 0 at the command edge, word 1 at the next edge |
| wr_lane_n | input | 2 | Active-low lane enables for the word on `wr_data` |
| rd_data | output | 18 | Read data, 0 when idle |
| rd_valid | output | 1 | High while `rd_data` carries a read word |
| cmd_beat | output | 1 | High when the next edge is a command edge |

## Verification
The assertions take for granted that the write buffer empties on every command edge. They also take for granted that reads start only on command edges, so no two reads reach the output stage on adjacent beats. The stimulus keeps to this by driving every command through one task. That task waits for `cmd_beat`, sets the selects only for the command edge and drops them on the second beat. The task also puts unrelated values on the address and data inputs in the beats where they must be ignored. The strap is changed only while reset is held, except in the one sequence that checks that a change during operation is ignored.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int WORD_W = 18;
  localparam int LANE_W = 9;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int BANKS  = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;

  // one read in flight: start flag and both burst words
  typedef struct packed {
    logic  valid;
    word_t w0;
    word_t w1;
  } rd_slot_t;

  // overlay lanes of new_w onto old_w where the active-low enable is 0
  function automatic word_t lane_merge(word_t old_w, word_t new_w, lane_t lane_n);
    word_t r;
    r = old_w;
    for (int i = 0; i < LANES; i++) begin
      if (!lane_n[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/sram_beat_clock.sv
module sram_beat_clock (
  input  logic clk,
  input  logic rst_n,
  input  logic lat_strap,
  output logic cmd_beat,
  output logic long_lat
);
  logic ph;

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end

  // strap latch: loads only during reset
  always_ff @(posedge clk) begin
    if (!rst_n) long_lat <= lat_strap;
  end

  assign cmd_beat = ~ph;

  assert_mode_stable_R11: assert property (@(posedge clk)
    disable iff (!rst_n) $past(rst_n) |-> $stable(long_lat));
endmodule

// File: rtl/sram_wr_stage.sv
module sram_wr_stage
  import sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_beat,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] wr_addr,
  input  word_t         wr_data,
  input  lane_t         wr_lane_n,
  output logic          buf_valid,
  output logic [AW-1:0] buf_addr,
  output word_t         buf_w0,
  output word_t         buf_w1,
  output lane_t         buf_l0,
  output lane_t         buf_l1,
  output logic          commit
);
  logic  pend;
  word_t st_w0;
  lane_t st_l0;

  // control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      buf_valid <= 1'b0;
    end else if (cmd_beat) begin
      pend      <= ~wr_sel_n;
      buf_valid <= 1'b0;
    end else begin
      pend      <= 1'b0;
      buf_valid <= pend;
    end
  end

  // datapath
  always_ff @(posedge clk) begin
    if (cmd_beat && !wr_sel_n) begin
      st_w0 <= wr_data;
      st_l0 <= wr_lane_n;
    end
    if (!cmd_beat && pend) begin
      buf_addr <= wr_addr;
      buf_w0   <= st_w0;
      buf_l0   <= st_l0;
      buf_w1   <= wr_data;
      buf_l1   <= wr_lane_n;
    end
  end

  assign commit = buf_valid & cmd_beat;

  assert_wbuf_one_beat_R4: assert property (@(posedge clk)
    disable iff (!rst_n) buf_valid |=> !buf_valid);
  assert_inflight_done_R10: assert property (@(posedge clk)
    disable iff (!rst_n) pend |=> buf_valid);
  assert_buf_on_cmd_beat_R9: assert property (@(posedge clk)
    disable iff (!rst_n) buf_valid |-> cmd_beat);
endmodule

// File: rtl/sram_bank.sv
module sram_bank
  import sram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  lane_t         wlane_n,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= lane_merge(mem[waddr], wdata, wlane_n);
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sram_rd_pipe.sv
module sram_rd_pipe
  import sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_beat,
  input  logic          long_lat,
  input  logic          rd_sel_n,
  input  logic [AW-1:0] rd_addr,
  input  word_t         arr_w0,
  input  word_t         arr_w1,
  input  logic          buf_valid,
  input  logic [AW-1:0] buf_addr,
  input  word_t         buf_w0,
  input  word_t         buf_w1,
  input  lane_t         buf_l0,
  input  lane_t         buf_l1,
  output word_t         rd_data,
  output logic          rd_valid
);
  localparam int SLOTS = 3;

  logic     rd_start, fwd_hit;
  word_t    fresh0, fresh1;
  rd_slot_t slot [SLOTS];
  logic     tail_v;
  word_t    tail_w;
  logic     hd_v, tl_v;
  word_t    hd_w, tl_w;

  assign rd_start = cmd_beat & ~rd_sel_n;
  assign fwd_hit  = buf_valid && (buf_addr == rd_addr);
  assign fresh0   = fwd_hit ? lane_merge(arr_w0, buf_w0, buf_l0) : arr_w0;
  assign fresh1   = fwd_hit ? lane_merge(arr_w1, buf_w1, buf_l1) : arr_w1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
      tail_v <= 1'b0;
      tail_w <= '0;
    end else begin
      slot[0] <= '{valid: rd_start, w0: fresh0, w1: fresh1};
      for (int i = 1; i < SLOTS; i++) slot[i] <= slot[i-1];
      tail_v <= slot[SLOTS-1].valid;
      tail_w <= slot[SLOTS-1].w1;
    end
  end

  // head word and tail word of the burst, stage picked by the latched strap
  always_comb begin
    hd_v = long_lat ? slot[2].valid : slot[1].valid;
    hd_w = long_lat ? slot[2].w0    : slot[1].w0;
    tl_v = long_lat ? tail_v        : slot[2].valid;
    tl_w = long_lat ? tail_w        : slot[2].w1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= hd_v | tl_v;
      rd_data  <= hd_v ? hd_w : (tl_v ? tl_w : '0);
    end
  end

  assert_start_on_cmd_beat_R3: assert property (@(posedge clk)
    disable iff (!rst_n) cmd_beat |-> !slot[0].valid);
  assert_burst_two_beats_R8: assert property (@(posedge clk)
    disable iff (!rst_n) $fell(rd_valid) |-> $past(rd_valid, 2));
  assert_no_stage_clash_R6: assert property (@(posedge clk)
    disable iff (!rst_n) $onehot0({slot[1].valid, slot[2].valid}));
endmodule

// File: rtl/dual_port_burst_sram.sv
module dual_port_burst_sram
  import sram_pkg::*;
#(
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_strap,
  input  logic          rd_sel_n,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] wr_addr,
  input  logic [17:0]   wr_data,
  input  logic [1:0]    wr_lane_n,
  output logic [17:0]   rd_data,
  output logic          rd_valid,
  output logic          cmd_beat
);
  logic          long_lat;
  logic          buf_valid, commit;
  logic [AW-1:0] buf_addr;
  word_t         buf_w0, buf_w1;
  lane_t         buf_l0, buf_l1;
  word_t         bank_wd [BANKS];
  lane_t         bank_ln [BANKS];
  word_t         bank_rd [BANKS];

  sram_beat_clock u_beat (
    .clk(clk), .rst_n(rst_n), .lat_strap(lat_strap),
    .cmd_beat(cmd_beat), .long_lat(long_lat)
  );

  sram_wr_stage #(.AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .cmd_beat(cmd_beat),
    .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wr_data(wr_data), .wr_lane_n(wr_lane_n),
    .buf_valid(buf_valid), .buf_addr(buf_addr),
    .buf_w0(buf_w0), .buf_w1(buf_w1), .buf_l0(buf_l0), .buf_l1(buf_l1),
    .commit(commit)
  );

  assign bank_wd[0] = buf_w0;
  assign bank_wd[1] = buf_w1;
  assign bank_ln[0] = buf_l0;
  assign bank_ln[1] = buf_l1;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sram_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk(clk), .we(commit), .waddr(buf_addr),
      .wdata(bank_wd[b]), .wlane_n(bank_ln[b]),
      .raddr(rd_addr), .rdata(bank_rd[b])
    );
  end

  sram_rd_pipe #(.AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .cmd_beat(cmd_beat), .long_lat(long_lat),
    .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
    .arr_w0(bank_rd[0]), .arr_w1(bank_rd[1]),
    .buf_valid(buf_valid), .buf_addr(buf_addr),
    .buf_w0(buf_w0), .buf_w1(buf_w1), .buf_l0(buf_l0), .buf_l1(buf_l1),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/sim_dual_port_burst_sram.sv
module sim_dual_port_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lat_strap = 1'b1;
  logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic [1:0] wr_lane_n = 2'b11;
  logic [17:0] rd_data;
  logic rd_valid, cmd_beat;

  int n_tests = 0, n_fail = 0, edge_n = 0;
  bit chk_on = 0, mode_long = 1, done = 0;
  logic [17:0] sh0 [DEPTH];
  logic [17:0] sh1 [DEPTH];
  bit          exp_v [16];
  logic [17:0] exp_d [16];
  string       exp_t [16];

  dual_port_burst_sram #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .lat_strap(lat_strap),
    .rd_sel_n(rd_sel_n), .rd_addr(rd_addr), .wr_sel_n(wr_sel_n), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_lane_n(wr_lane_n),
    .rd_data(rd_data), .rd_valid(rd_valid), .cmd_beat(cmd_beat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edge_n++;

  task automatic chk(bit ok, string tag, logic [18:0] act, logic [18:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference output, compared on every beat
  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      int idx;
      idx = edge_n % 16;
      if (exp_v[idx])
        chk(rd_valid === 1'b1 && rd_data === exp_d[idx], exp_t[idx],
            {rd_valid, rd_data}, {1'b1, exp_d[idx]});
      else
        chk(rd_valid === 1'b0 && rd_data === 18'd0, "R8 idle output",
            {rd_valid, rd_data}, 19'd0);
      exp_v[idx] = 0;
    end
  end

  function automatic logic [17:0] apply_lanes(logic [17:0] old, logic [17:0] d, logic [1:0] ln);
    logic [17:0] m;
    m = {{9{~ln[1]}}, {9{~ln[0]}}};
    return (old & ~m) | (d & m);
  endfunction

  task automatic cmd(bit re, int ra, bit we, int wa, logic [17:0] d0, logic [17:0] d1,
                     logic [1:0] l0, logic [1:0] l1, string tag);
    int k, off;
    @(posedge clk); #1;
    while (!cmd_beat) begin @(posedge clk); #1; end
    rd_sel_n = !re; rd_addr = AW'(ra);
    wr_sel_n = !we; wr_data = d0; wr_lane_n = l0;
    wr_addr = ~AW'(wa);
    if (re) begin
      k = edge_n + 1;
      off = mode_long ? 3 : 2;
      exp_v[(k+off)%16] = 1; exp_d[(k+off)%16] = sh0[ra]; exp_t[(k+off)%16] = {tag, " word0"};
      exp_v[(k+off+1)%16] = 1; exp_d[(k+off+1)%16] = sh1[ra]; exp_t[(k+off+1)%16] = {tag, " word1"};
    end
    @(posedge clk); #1;
    rd_sel_n = 1'b1; wr_sel_n = 1'b1; rd_addr = ~AW'(ra);
    wr_addr = AW'(wa); wr_data = d1; wr_lane_n = l1;
    if (we) begin
      sh0[wa] = apply_lanes(sh0[wa], d0, l0);
      sh1[wa] = apply_lanes(sh1[wa], d1, l1);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cmd(0, 0, 0, 0, 18'h0, 18'h0, 2'b11, 2'b11, "R8");
  endtask

  task automatic do_reset(bit strap);
    chk_on = 0;
    @(posedge clk); #1;
    rst_n = 1'b0; lat_strap = strap;
    repeat (4) @(posedge clk);
    #1;
    chk(rd_valid === 1'b0 && rd_data === 18'd0, "R12 output in reset",
        {rd_valid, rd_data}, 19'd0);
    for (int i = 0; i < 16; i++) exp_v[i] = 0;
    mode_long = strap;
    rst_n = 1'b1;
    chk(cmd_beat === 1'b1, "R2 beat after release", {18'd0, cmd_beat}, 19'd1);
    chk_on = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    @(posedge clk); #1;
    chk(cmd_beat === 1'b0, "R2 toggle 1", {18'd0, cmd_beat}, 19'd0);
    @(posedge clk); #1;
    chk(cmd_beat === 1'b1, "R2 toggle 2", {18'd0, cmd_beat}, 19'd1);

    // fill memory (R4), reading back concurrently from two cycles earlier
    for (int a = 0; a < DEPTH; a++)
      cmd(a >= 2, (a >= 2) ? a - 2 : 0, 1, a, 18'(a * 37 + 5), 18'(a * 1021 + 3),
          2'b00, 2'b00, "R4");
    idle(3);

    // plain reads, boundaries included (R3, R7)
    cmd(1, 0, 0, 0, 0, 0, 2'b11, 2'b11, "R3 addr0 R7");
    cmd(1, 255, 0, 0, 0, 0, 2'b11, 2'b11, "R3 addr255 R7");
    cmd(1, 128, 0, 0, 0, 0, 2'b11, 2'b11, "R7");
    idle(3);

    // concurrent read and write at different addresses (R1)
    for (int i = 0; i < 8; i++)
      cmd(1, 200 + i, 1, 10 + i, 18'h3_0000 + 18'(i), 18'h1_5555 ^ 18'(i), 2'b00, 2'b00, "R1");
    for (int i = 0; i < 8; i++) cmd(1, 10 + i, 0, 0, 0, 0, 2'b11, 2'b11, "R1 readback");
    idle(3);

    // lane enables (R5)
    cmd(0, 0, 1, 40, 18'h3_FFFF, 18'h0_0000, 2'b10, 2'b01, "R5");
    cmd(0, 0, 1, 41, 18'h2_AAAA, 18'h1_2345, 2'b01, 2'b11, "R5");
    cmd(0, 0, 1, 42, 18'h3_FFFF, 18'h3_FFFF, 2'b11, 2'b11, "R5");
    idle(2);
    cmd(1, 40, 0, 0, 0, 0, 2'b11, 2'b11, "R5 lanes");
    cmd(1, 41, 0, 0, 0, 0, 2'b11, 2'b11, "R5 lanes");
    cmd(1, 42, 0, 0, 0, 0, 2'b11, 2'b11, "R5 lanes");
    idle(3);

    // forwarding (R9): same edge sees old, next cycle sees new
    cmd(1, 60, 1, 60, 18'h1_1111, 18'h2_2222, 2'b00, 2'b00, "R9 same edge");
    cmd(1, 60, 0, 0, 0, 0, 2'b11, 2'b11, "R9 next cycle");
    cmd(0, 0, 1, 61, 18'h0_ABCD, 18'h3_0F0F, 2'b01, 2'b10, "R9");
    cmd(1, 61, 1, 61, 18'h3_3333, 18'h0_4444, 2'b00, 2'b00, "R9 lane forward");
    cmd(1, 61, 0, 0, 0, 0, 2'b11, 2'b11, "R9 chained");
    idle(3);

    // deselected write ignores inputs, in-flight write completes (R10)
    cmd(0, 0, 0, 70, 18'h3_DEAD, 18'h3_BEEF, 2'b00, 2'b00, "R10");
    cmd(0, 0, 0, 71, 18'h2_0000, 18'h2_0001, 2'b00, 2'b00, "R10");
    cmd(1, 70, 0, 0, 0, 0, 2'b11, 2'b11, "R10 untouched");
    cmd(1, 71, 1, 72, 18'h1_0707, 18'h2_0808, 2'b00, 2'b00, "R10 untouched");
    cmd(1, 72, 0, 0, 0, 0, 2'b11, 2'b11, "R10 completed");
    idle(3);

    // strap changed during operation is ignored (R11)
    lat_strap = 1'b0;
    cmd(1, 5, 0, 0, 0, 0, 2'b11, 2'b11, "R11 latency held");
    cmd(1, 6, 0, 0, 0, 0, 2'b11, 2'b11, "R11 latency held");
    idle(3);

    // short latency after reset with strap low (R6, R12)
    do_reset(1'b0);
    lat_strap = 1'b1;
    cmd(1, 0, 0, 0, 0, 0, 2'b11, 2'b11, "R6 R12 contents kept");
    cmd(1, 255, 1, 90, 18'h0_1234, 18'h3_4321, 2'b00, 2'b00, "R6");
    cmd(1, 90, 0, 0, 0, 0, 2'b11, 2'b11, "R6 R9");
    cmd(1, 41, 0, 0, 0, 0, 2'b11, 2'b11, "R6");
    idle(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule